// File: doc/BRIEF.md
# Valley-Switching Gate Restart Sequencer

This block decides, clock by clock, when the single power switch of a flyback converter turns on and when it turns off. The converter runs at the edge of discontinuous conduction: the switch turns on again once the transformer has emptied and the drain ringing has reached a valley. The block sees that valley as a digitized zero-crossing flag from an auxiliary winding. It ends each on-time when a peak-current comparator trips. The analog comparators, the oscillator ramp and the gate driver stay outside the block, which only handles their logic-level flags.

Two restart policies exist. In free-running mode every qualifying zero-crossing edge restarts the switch. In foldback mode a tick from the oscillator is stored first, and only the zero-crossing edge that follows a stored tick restarts the switch. This lowers the switching rate at light load while keeping valley alignment. Several rules apply in both modes. A minimum period caps the switching rate. A blanking window after each turn-on masks the current comparator. When the ringing has died out, a timeout forces a restart on the next oscillator tick. A supervisor enable forces the gate off.

Top module: `qr_gate_seq`

## Requirements
- R1: After synchronous reset the gate output is low, and it stays low while no zero-crossing edge and no oscillator tick arrive and the timeout has not expired.
- R2: With `mode_i` = 0 (free-running), a rise of `zcd_i` passes through a two-flop synchronizer and a one-flop edge detector. The gate goes high on the third rising clock edge after the input rises, provided the gate is off, the block is enabled and the minimum period has elapsed.
- R3: A zero-crossing rise that arrives while the gate is high is dropped. It does not cause a turn-on after the gate falls.
- R4: Two turn-ons are at least `MIN_PERIOD_CYC` clock cycles apart. A restart event that arrives sooner is dropped, not deferred.
- R5: During the first `BLANK_CYC` clock edges after a turn-on, `ilim_i` is ignored. If `ilim_i` is held high from the turn-on, the gate stays high for exactly `BLANK_CYC` cycles.
- R6: After the blanking window, `ilim_i` high drives the gate low on the next clock edge. Without a trip the gate holds high.
- R7: With `mode_i` = 1 (foldback), a high `osc_tick_i` stores a restart request. A zero-crossing rise turns the gate on only while a request is stored. The turn-on consumes the request.
- R8: The timeout counter restarts on every turn-on and on every zero-crossing rise seen while the gate is off. After `TIMEOUT_CYC` cycles without either event, a high `osc_tick_i` turns the gate on at the next edge. Before the timeout expires, a tick does not turn on the gate in free-running mode.
- R9: When `run_en_i` is low, the gate goes low on the next edge, no turn-on occurs, and any stored foldback request is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en_i | input | 1 | Supervisor enable; low forces the gate off |
| mode_i | input | 1 | 0 = free-running restart, 1 = foldback restart |
| zcd_i | input | 1 | Asynchronous zero-crossing flag from the auxiliary winding |
| ilim_i | input | 1 | Peak-current comparator trip |
| osc_tick_i | input | 1 | One-cycle oscillator tick |
| gate_o | output | 1 | Registered gate-drive enable |

## Verification
The bench builds the block with `BLANK_CYC` = 4, `MIN_PERIOD_CYC` = 20 and `TIMEOUT_CYC` = 60. With these values a dead-ring timeout expires after a few dozen cycles, instead of the several hundred thousand cycles that a 4 ms default needs. Blanking boundaries and too-early restarts also fall within short directed sequences. The small minimum period lets a test place a zero-crossing edge both inside and outside the rate clamp. The sequences use only the ports. They also cover an edge that lands during the on-time and a foldback request that is cancelled by the enable.

// File: rtl/qr_pkg.sv
package qr_pkg;
  typedef enum logic {
    MODE_FREE = 1'b0,
    MODE_FOLD = 1'b1
  } qr_mode_e;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/qr_sync_edge.sv
module qr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  // sh_q[STAGES-1] is the last synchronizer stage, sh_q[STAGES] its history
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/qr_span_timer.sv
module qr_span_timer #(
  parameter int W        = 8,
  parameter int LIM      = 10,
  parameter bit RST_FULL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam logic [W-1:0] LIM_V = W'(LIM);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= RST_FULL ? LIM_V : '0;
    else if (clr)           cnt_q <= '0;
    else if (cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIM_V);
endmodule

// File: rtl/qr_start_logic.sv
module qr_start_logic
  import qr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run_en,
  input  qr_mode_e mode,
  input  logic     zc_rise,
  input  logic     tick,
  input  logic     tmo_done,
  input  logic     per_ok,
  input  logic     gate_on,
  output logic     turn_on
);
  logic req_q;
  logic zc_go;
  logic tmo_go;

  // a zero-crossing edge restarts directly when free-running, or with a stored tick
  assign zc_go   = zc_rise & ((mode == MODE_FREE) | req_q);
  assign tmo_go  = tmo_done & tick;
  assign turn_on = run_en & ~gate_on & per_ok & (zc_go | tmo_go);

  always_ff @(posedge clk) begin
    if (rst || !run_en)                      req_q <= 1'b0;
    else if (turn_on)                        req_q <= 1'b0;
    else if (mode == MODE_FOLD && tick)      req_q <= 1'b1;
  end
endmodule

// File: rtl/qr_gate_seq.sv
module qr_gate_seq
  import qr_pkg::*;
#(
  parameter int BLANK_CYC      = 20,
  parameter int MIN_PERIOD_CYC = 800,
  parameter int TIMEOUT_CYC    = 400000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en_i,
  input  logic mode_i,
  input  logic zcd_i,
  input  logic ilim_i,
  input  logic osc_tick_i,
  output logic gate_o
);
  localparam int BLK_W = cnt_width(BLANK_CYC);
  localparam int PER_W = cnt_width(MIN_PERIOD_CYC);
  localparam int TMO_W = cnt_width(TIMEOUT_CYC);

  qr_mode_e mode;
  logic     zc_rise;
  logic     turn_on;
  logic     blank_done;
  logic     per_ok;
  logic     tmo_done;
  logic     trip;
  logic     gate_q;

  assign mode = qr_mode_e'(mode_i);

  qr_sync_edge #(.STAGES(SYNC_STAGES)) u_zcd (
    .clk (clk),
    .rst (rst),
    .din (zcd_i),
    .rise(zc_rise)
  );

  // rate clamp: counts cycles since the last turn-on
  qr_span_timer #(.W(PER_W), .LIM(MIN_PERIOD_CYC - 1), .RST_FULL(1'b1)) u_period (
    .clk (clk),
    .rst (rst),
    .clr (turn_on),
    .done(per_ok)
  );

  // comparator mask window after turn-on
  qr_span_timer #(.W(BLK_W), .LIM(BLANK_CYC - 1), .RST_FULL(1'b1)) u_blank (
    .clk (clk),
    .rst (rst),
    .clr (turn_on),
    .done(blank_done)
  );

  // dead-ring fallback: restarts on turn-on or on an off-time zero crossing
  qr_span_timer #(.W(TMO_W), .LIM(TIMEOUT_CYC - 1), .RST_FULL(1'b0)) u_timeout (
    .clk (clk),
    .rst (rst),
    .clr (turn_on | (zc_rise & ~gate_q)),
    .done(tmo_done)
  );

  qr_start_logic u_start (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en_i),
    .mode    (mode),
    .zc_rise (zc_rise),
    .tick    (osc_tick_i),
    .tmo_done(tmo_done),
    .per_ok  (per_ok),
    .gate_on (gate_q),
    .turn_on (turn_on)
  );

  assign trip = gate_q & blank_done & ilim_i;

  always_ff @(posedge clk) begin
    if (rst || !run_en_i) gate_q <= 1'b0;
    else if (turn_on)     gate_q <= 1'b1;
    else if (trip)        gate_q <= 1'b0;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/qr_gate_seq_chk.sv
module qr_gate_seq_chk
  import qr_pkg::*;
#(
  parameter int BLANK_CYC      = 20,
  parameter int MIN_PERIOD_CYC = 800
) (
  input logic clk,
  input logic rst,
  input logic run_en_i,
  input logic ilim_i,
  input logic gate_o
);
  localparam int ON_W  = cnt_width(BLANK_CYC);
  localparam int GAP_W = cnt_width(MIN_PERIOD_CYC);
  localparam logic [ON_W-1:0]  ON_MAX  = ON_W'(BLANK_CYC);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_PERIOD_CYC);

  logic [ON_W-1:0]  on_len;
  logic [GAP_W-1:0] gap;
  logic             gate_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_len <= '0;
      gap    <= GAP_MAX;
      gate_d <= 1'b0;
    end else begin
      gate_d <= gate_o;
      if (!gate_o)              on_len <= '0;
      else if (on_len != ON_MAX) on_len <= on_len + 1'b1;
      if (gate_o && !gate_d)    gap <= '0;
      else if (gap != GAP_MAX)  gap <= gap + 1'b1;
    end
  end

  p_disable_forces_off_r9: assert property (@(posedge clk) disable iff (rst)
    !run_en_i |=> !gate_o);

  p_blank_min_on_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_o) && $past(run_en_i)) |-> (int'(on_len) >= BLANK_CYC));

  p_trip_turns_off_r6: assert property (@(posedge clk) disable iff (rst)
    (gate_o && ilim_i && int'(on_len) >= BLANK_CYC - 1) |=> !gate_o);

  p_min_period_r4: assert property (@(posedge clk) disable iff (rst)
    (gate_o && !gate_d) |-> (int'(gap) >= MIN_PERIOD_CYC - 1));
endmodule

bind qr_gate_seq qr_gate_seq_chk #(
  .BLANK_CYC     (BLANK_CYC),
  .MIN_PERIOD_CYC(MIN_PERIOD_CYC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run_en_i(run_en_i),
  .ilim_i  (ilim_i),
  .gate_o  (gate_o)
);

// File: tb/qr_gate_seq_tb.sv
module qr_gate_seq_tb;
  localparam int BLANK = 4;
  localparam int MINP  = 20;
  localparam int TMO   = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic mode = 1'b0;
  logic zcd = 1'b0;
  logic ilim = 1'b0;
  logic tick = 1'b0;
  logic gate;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  qr_gate_seq #(
    .BLANK_CYC     (BLANK),
    .MIN_PERIOD_CYC(MINP),
    .TIMEOUT_CYC   (TMO)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .run_en_i  (en),
    .mode_i    (mode),
    .zcd_i     (zcd),
    .ilim_i    (ilim),
    .osc_tick_i(tick),
    .gate_o    (gate)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_dut(input logic m);
    rst = 1'b1; en = 1'b1; mode = m; zcd = 1'b0; ilim = 1'b0; tick = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    reset_dut(1'b0);
    chk(gate == 1'b0, "R1 gate after reset", int'(gate), 0);
    step(20);
    chk(gate == 1'b0, "R1 gate idle", int'(gate), 0);
  endtask

  task automatic t_free_latency();
    reset_dut(1'b0);
    zcd = 1'b1;
    step(1); chk(gate == 1'b0, "R2 edge+1", int'(gate), 0);
    step(1); chk(gate == 1'b0, "R2 edge+2", int'(gate), 0);
    step(1); chk(gate == 1'b1, "R2 edge+3 turn-on", int'(gate), 1);
  endtask

  task automatic t_blank();
    int highs = 0;
    reset_dut(1'b0);
    zcd = 1'b1;
    step(3);
    ilim = 1'b1; zcd = 1'b0;
    while (gate && highs < 50) begin
      highs++;
      step(1);
    end
    chk(highs == BLANK, "R5 on-time with trip held", highs, BLANK);
    ilim = 1'b0;
  endtask

  task automatic t_trip();
    reset_dut(1'b0);
    zcd = 1'b1;
    step(3);
    zcd = 1'b0;
    step(10);
    chk(gate == 1'b1, "R6 holds without trip", int'(gate), 1);
    ilim = 1'b1;
    step(1);
    chk(gate == 1'b0, "R6 trip turns off", int'(gate), 0);
    ilim = 1'b0;
  endtask

  task automatic t_min_period();
    int highs = 0;
    reset_dut(1'b0);
    zcd = 1'b1;
    step(3);
    ilim = 1'b1; zcd = 1'b0;
    step(4);
    chk(gate == 1'b0, "R5 off after blanking", int'(gate), 0);
    ilim = 1'b0; zcd = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (gate) highs++;
    end
    chk(highs == 0, "R4 early edge dropped", highs, 0);
    zcd = 1'b0;
    step(8);
    zcd = 1'b1;
    step(3);
    chk(gate == 1'b1, "R4 edge after period", int'(gate), 1);
  endtask

  task automatic t_edge_while_on();
    int highs = 0;
    reset_dut(1'b0);
    zcd = 1'b1;
    step(3);
    zcd = 1'b0;
    step(20);
    zcd = 1'b1;
    step(10);
    chk(gate == 1'b1, "R3 still on", int'(gate), 1);
    ilim = 1'b1;
    step(1);
    ilim = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (gate) highs++;
      step(1);
    end
    chk(highs == 0, "R3 on-time edge discarded", highs, 0);
  endtask

  task automatic t_fold();
    reset_dut(1'b1);
    zcd = 1'b1;
    step(3); chk(gate == 1'b0, "R7 edge without request", int'(gate), 0);
    step(5); chk(gate == 1'b0, "R7 still off", int'(gate), 0);
    zcd = 1'b0;
    step(3);
    tick = 1'b1; step(1); tick = 1'b0;
    step(3);
    chk(gate == 1'b0, "R7 tick alone", int'(gate), 0);
    zcd = 1'b1;
    step(3);
    chk(gate == 1'b1, "R7 edge after tick", int'(gate), 1);
    ilim = 1'b1; zcd = 1'b0;
    step(BLANK + 1);
    chk(gate == 1'b0, "R6 fold trip", int'(gate), 0);
    ilim = 1'b0;
    step(20);
    zcd = 1'b1;
    step(3); chk(gate == 1'b0, "R7 request consumed", int'(gate), 0);
    step(3); chk(gate == 1'b0, "R7 request consumed late", int'(gate), 0);
  endtask

  task automatic t_timeout();
    reset_dut(1'b0);
    step(30);
    tick = 1'b1; step(1); tick = 1'b0;
    chk(gate == 1'b0, "R8 tick before expiry", int'(gate), 0);
    step(40);
    chk(gate == 1'b0, "R8 expiry waits for tick", int'(gate), 0);
    tick = 1'b1; step(1); tick = 1'b0;
    chk(gate == 1'b1, "R8 forced restart", int'(gate), 1);
    // zero-crossing edge in foldback mode restarts the timeout
    reset_dut(1'b1);
    step(40);
    zcd = 1'b1;
    step(5);
    zcd = 1'b0;
    step(30);
    tick = 1'b1; step(1); tick = 1'b0;
    step(1);
    chk(gate == 1'b0, "R8 timer restarted by edge", int'(gate), 0);
    step(30);
    tick = 1'b1; step(1); tick = 1'b0;
    chk(gate == 1'b1, "R8 restart after new expiry", int'(gate), 1);
  endtask

  task automatic t_enable();
    reset_dut(1'b0);
    zcd = 1'b1;
    step(3);
    chk(gate == 1'b1, "R9 on before disable", int'(gate), 1);
    en = 1'b0;
    step(1);
    chk(gate == 1'b0, "R9 disable forces off", int'(gate), 0);
    zcd = 1'b0;
    step(5);
    zcd = 1'b1;
    step(5);
    chk(gate == 1'b0, "R9 no turn-on while disabled", int'(gate), 0);
    en = 1'b1;
    step(3);
    chk(gate == 1'b0, "R9 stays off after enable", int'(gate), 0);
    reset_dut(1'b1);
    tick = 1'b1; step(1); tick = 1'b0;
    en = 1'b0; step(1); en = 1'b1;
    zcd = 1'b1;
    step(3); chk(gate == 1'b0, "R9 request cleared", int'(gate), 0);
    step(3); chk(gate == 1'b0, "R9 request cleared late", int'(gate), 0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_free_latency();
    t_blank();
    t_trip();
    t_min_period();
    t_edge_while_on();
    t_fold();
    t_timeout();
    t_enable();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule